// File: doc/BRIEF.md
# Manchester Line Transmitter with Programmable Preamble

This block turns one byte into a self-clocking Manchester-coded line stream. Each transmitted symbol occupies one bit period that is split into two half phases. The second half is always the complement of the first, so every symbol has a transition at mid-bit. A frame may begin with a preamble of 0 to 15 symbols in one of four patterns. One start symbol of logic zero follows with no gap, and then the eight data bits, least significant bit first. A polarity setting swaps the transition direction used for zero and one. The swap applies to preamble, start and data symbols alike.

The byte arrives through a valid/ready handshake. Preamble length, pattern and polarity are captured together with the byte when it is accepted, so the settings can change freely while a frame is on the line. Timing comes from an external half-bit enable: every clock cycle in which it is high ends the half phase currently on the line. Between frames the line rests high with no transitions.

Top module: `manchester_tx`

## Requirements
- R1: With no frame in progress, the line output is constant high and the ready output is high, even while half-bit ticks arrive.
- R2: A byte is accepted in a cycle where valid and ready are both high. Ready is low from the next cycle until the tick that ends the last half of the last data symbol, and it is high again in the cycle after that tick.
- R3: Each symbol spans exactly two half phases, and each half-bit tick advances exactly one half phase. The second half of a symbol is the complement of the first half.
- R4: With polarity setting 0, logic zero is sent as low then high, and logic one is sent as high then low.
- R5: With polarity setting 1, logic zero is sent as high then low, and logic one is sent as low then high. Preamble symbols are coded the same way.
- R6: Preamble length 0 means no preamble: the start symbol is the first symbol of the frame.
- R7: Preamble length N (1 to 15) puts exactly N preamble symbols on the line immediately before the start symbol.
- R8: Preamble pattern code 0 sends all ones and code 1 sends all zeros. Code 2 sends 0,1,0,1,... and code 3 sends 1,0,1,0,..., counting from the first preamble symbol. These are logical symbol values, coded per R4 and R5.
- R9: After the preamble comes one start symbol of logic zero, then data bits 0 through 7 in that order. After the last data symbol the line returns high, and no stop symbol is sent.
- R10: The data byte, preamble length, pattern and polarity are sampled at acceptance. Changing those inputs while a frame is in progress leaves that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_tick | input | 1 | Half-bit enable: ends the current half phase |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter idle and able to accept a byte |
| in_data | input | 8 | Byte to send |
| cfg_pre_len | input | 4 | Preamble length in symbols, 0 disables |
| cfg_pre_pat | input | 2 | Preamble pattern code |
| cfg_invert | input | 1 | Polarity setting |
| line_out | output | 1 | Manchester-coded line |

## Verification
The assertions check the cycle-level rules on every cycle:
- the line is high while idle;
- a half phase advanced within a symbol always flips the line;
- ready drops after a handshake;
- captured settings stay still during a frame;
- the symbol counter never passes the start-plus-data boundary;
- the start symbol is logic zero.

Only the bench's directed frames can show the following, because each one needs the full expected half-phase sequence of a frame:
- the preamble patterns;
- the bit order;
- the polarity mapping;
- that mid-frame input changes are ignored.

// File: rtl/mtx_pkg.sv
// Shared types for the Manchester transmitter.
// Assumes preamble pattern codes are two bits wide.
package mtx_pkg;
    typedef enum logic [1:0] {
        PAT_ONES  = 2'd0,
        PAT_ZEROS = 2'd1,
        PAT_ZO    = 2'd2,
        PAT_OZ    = 2'd3
    } pre_pat_e;
endpackage

// File: rtl/mtx_seq.sv
// Frame sequencer: accepts a byte with its settings, then steps through
// preamble, start and data symbols, two half phases per symbol.
// Assumes half_tick is a single-cycle enable supplied from outside.
module mtx_seq
    import mtx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PL_W   = 4,
    localparam int CNT_W = $clog2((1 << PL_W) + DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [PL_W-1:0]   cfg_pre_len,
    input  logic [1:0]        cfg_pre_pat,
    input  logic              cfg_invert,
    output logic              busy,
    output logic              half,
    output logic [CNT_W-1:0]  sym_idx,
    output logic [DATA_W-1:0] data_q,
    output logic [PL_W-1:0]   len_q,
    output pre_pat_e          pat_q,
    output logic              pol_q
);
    logic             accept;
    logic [CNT_W-1:0] last_idx;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;
    assign last_idx = CNT_W'(len_q) + CNT_W'(DATA_W);

    // Capture the byte and settings when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            len_q  <= '0;
            pat_q  <= PAT_ONES;
            pol_q  <= 1'b0;
        end else if (accept) begin
            data_q <= in_data;
            len_q  <= cfg_pre_len;
            pat_q  <= pre_pat_e'(cfg_pre_pat);
            pol_q  <= cfg_invert;
        end
    end

    // Advance half phase and symbol index; leave busy after the last half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            half    <= 1'b0;
            sym_idx <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            half    <= 1'b0;
            sym_idx <= '0;
        end else if (busy && half_tick) begin
            half <= !half;
            if (half) begin
                if (sym_idx == last_idx) begin
                    busy    <= 1'b0;
                    sym_idx <= '0;
                end else begin
                    sym_idx <= sym_idx + 1'b1;
                end
            end
        end
    end

    p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(len_q) && $stable(pol_q)
                                   && $stable(pat_q) && $stable(data_q)));

    p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sym_idx <= last_idx));
endmodule

// File: rtl/mtx_sym_sel.sv
// Symbol selector: returns the logical value of the current symbol.
// Preamble symbols come first, then a zero start symbol, then data LSB first.
// Assumes sym_idx never exceeds len_q + DATA_W.
module mtx_sym_sel
    import mtx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PL_W   = 4,
    localparam int CNT_W = $clog2((1 << PL_W) + DATA_W + 1),
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic [CNT_W-1:0]  sym_idx,
    input  logic [PL_W-1:0]   len_q,
    input  pre_pat_e          pat_q,
    input  logic [DATA_W-1:0] data_q,
    output logic              sym_bit
);
    logic [CNT_W-1:0] off;
    logic [CNT_W-1:0] off_m1;

    assign off    = sym_idx - CNT_W'(len_q);
    assign off_m1 = off - 1'b1;

    // Choose preamble pattern bit, start zero, or data bit.
    always_comb begin
        if (sym_idx < CNT_W'(len_q)) begin
            unique case (pat_q)
                PAT_ONES:  sym_bit = 1'b1;
                PAT_ZEROS: sym_bit = 1'b0;
                PAT_ZO:    sym_bit = sym_idx[0];
                PAT_OZ:    sym_bit = !sym_idx[0];
                default:   sym_bit = 1'b1;
            endcase
        end else if (off == '0) begin
            sym_bit = 1'b0;
        end else begin
            sym_bit = data_q[off_m1[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/mtx_coder.sv
// Half-bit coder: maps symbol value, half phase and polarity to a line level.
// Assumes the line rests high whenever no frame is active.
module mtx_coder (
    input  logic busy,
    input  logic half,
    input  logic sym_bit,
    input  logic pol,
    output logic line
);
    // First half carries symbol xor polarity; second half is its complement.
    always_comb begin
        if (!busy) line = 1'b1;
        else       line = sym_bit ^ pol ^ half;
    end
endmodule

// File: rtl/manchester_tx.sv
// Manchester transmitter top: sequencer, symbol selector and half-bit coder.
// Assumes an external half-bit enable; line_out is decoded from registers.
module manchester_tx
    import mtx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PL_W   = 4,
    localparam int CNT_W = $clog2((1 << PL_W) + DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [PL_W-1:0]   cfg_pre_len,
    input  logic [1:0]        cfg_pre_pat,
    input  logic              cfg_invert,
    output logic              line_out
);
    logic              busy;
    logic              half;
    logic [CNT_W-1:0]  sym_idx;
    logic [DATA_W-1:0] data_q;
    logic [PL_W-1:0]   len_q;
    pre_pat_e          pat_q;
    logic              pol_q;
    logic              sym_bit;

    mtx_seq #(.DATA_W(DATA_W), .PL_W(PL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .cfg_pre_len(cfg_pre_len), .cfg_pre_pat(cfg_pre_pat),
        .cfg_invert(cfg_invert), .busy(busy), .half(half),
        .sym_idx(sym_idx), .data_q(data_q), .len_q(len_q),
        .pat_q(pat_q), .pol_q(pol_q)
    );

    mtx_sym_sel #(.DATA_W(DATA_W), .PL_W(PL_W)) u_sel (
        .sym_idx(sym_idx), .len_q(len_q), .pat_q(pat_q),
        .data_q(data_q), .sym_bit(sym_bit)
    );

    mtx_coder u_coder (
        .busy(busy), .half(half), .sym_bit(sym_bit), .pol(pol_q),
        .line(line_out)
    );

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    p_mid_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && half && $past(busy && !half)) |-> (line_out != $past(line_out)));

    p_start_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sym_idx == CNT_W'(len_q)) |-> !sym_bit);
endmodule

// File: tb/test_manchester_tx.sv
module test_manchester_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [3:0] cfg_pre_len = '0;
    logic [1:0] cfg_pre_pat = '0;
    logic       cfg_invert = 1'b0;
    logic       line_out;
    int         total = 0;
    int         bad = 0;

    always #2 clk = !clk;

    manchester_tx i_manchester_tx (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .cfg_pre_len(cfg_pre_len), .cfg_pre_pat(cfg_pre_pat),
        .cfg_invert(cfg_invert), .line_out(line_out)
    );

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic exp_sym(int k, int len, int pat, logic [7:0] d);
        if (k < len) begin
            case (pat)
                0: return 1'b1;
                1: return 1'b0;
                2: return (k % 2) == 1;
                default: return (k % 2) == 0;
            endcase
        end
        if (k == len) return 1'b0;
        return d[k - len - 1];
    endfunction

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
        end
    endtask

    // Sends one frame, checking every half phase, ready and the return to idle.
    task automatic run_frame(string req, logic [7:0] d, int len, int pat,
                             logic pol, bit disturb);
        int   nh;
        int   errs = 0;
        int   first_i = -1;
        logic first_act = 1'b0;
        logic first_exp = 1'b0;
        logic rdy_bad = 1'b0;
        nh = 2 * (len + 9);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; cfg_pre_len = 4'(len);
        cfg_pre_pat = 2'(pat); cfg_invert = pol;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R2 ready low after accept"}, in_ready, 1'b0);
        if (disturb) begin
            in_data = ~d; cfg_pre_len = 4'(len + 3);
            cfg_pre_pat = 2'(pat + 1); cfg_invert = !pol;
        end
        for (int i = 0; i < nh; i++) begin
            logic s;
            logic e;
            s = exp_sym(i / 2, len, pat, d);
            e = s ^ pol ^ logic'(i % 2);
            if (in_ready !== 1'b0) rdy_bad = 1'b1;
            if (line_out !== e) begin
                errs++;
                if (first_i < 0) begin
                    first_i = i; first_act = line_out; first_exp = e;
                end
            end
            half_tick = 1'b1;
            @(negedge clk);
            half_tick = 1'b0;
            if (i % 3 == 0) @(negedge clk);
        end
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s: half %0d act=%0b exp=%0b", req, first_i,
                     first_act, first_exp);
        end
        check({req, " R2 ready held low during frame"}, rdy_bad, 1'b0);
        check({req, " R2 ready back after frame"}, in_ready, 1'b1);
        check({req, " R9 line high after frame"}, line_out, 1'b1);
        in_data = '0; cfg_pre_len = '0; cfg_pre_pat = '0; cfg_invert = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset line", line_out, 1'b1);
        check("R1 reset ready", in_ready, 1'b1);
    endtask

    task automatic t_idle_ticks();
        logic moved = 1'b0;
        for (int i = 0; i < 10; i++) begin
            half_tick = 1'b1;
            @(negedge clk);
            half_tick = 1'b0;
            if (line_out !== 1'b1 || in_ready !== 1'b1) moved = 1'b1;
        end
        check("R1 idle line constant under ticks", moved, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ticks();
        run_frame("R4 R6 R9 pol0 no preamble", 8'hA5, 0, 0, 1'b0, 1'b0);
        run_frame("R5 R6 pol1 no preamble", 8'h3C, 0, 0, 1'b1, 1'b0);
        run_frame("R7 R8 len3 ones", 8'h81, 3, 0, 1'b0, 1'b0);
        run_frame("R5 R8 len4 zeros pol1", 8'h5A, 4, 1, 1'b1, 1'b0);
        run_frame("R8 len5 zero-one", 8'hF0, 5, 2, 1'b0, 1'b0);
        run_frame("R8 len6 one-zero", 8'h0F, 6, 3, 1'b0, 1'b0);
        run_frame("R7 R8 len15 one-zero pol1", 8'hC3, 15, 3, 1'b1, 1'b0);
        run_frame("R10 mid-frame input change", 8'h96, 2, 2, 1'b0, 1'b1);
        run_frame("R3 R9 all ones data", 8'hFF, 1, 1, 1'b0, 1'b0);
        t_idle_ticks();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule